// File: doc/BRIEF.md
# GPIO Interrupt Sense Controller

This block watches a vector of already synchronised input lines and turns selected transitions or levels on them into sticky pending flags. Each line owns a two-bit sense code. The codes for the lower half of the lines are held in one control register and the codes for the upper half in a second one. A pending flag stays set until software writes a one to it. A mask register chooses which pending flags may raise the single combined interrupt output. The block also holds a direction register in which a parameter can tie a group of four lines to input only.

Access uses a simple register port: a write strobe, a byte offset, write data and combinational read data. Line n sits at bit (LINES-1-n) of the direction, pending and mask registers and of the input vector, so line 0 is the most significant bit. The parameter `LEVEL_MODE` chooses what the codes 01 and 10 mean. With `LEVEL_MODE` at 0 they detect a rising or a falling edge. With `LEVEL_MODE` at 1 they detect an active-high or an active-low level.

A two-state arming machine runs after reset. In `ST_PRIME` it loads the previous-sample register from the inputs and allows no detection. The transition `PRIME_DONE` then moves it to `ST_ARMED`, where detection runs. `ST_ARMED` only loops back to itself (`STAY_ARMED`) until the next reset.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset the direction, pending, mask and both sense registers read 0 and `irq_o` is 0. In the first clock after reset no pending flag is set, whatever the input levels are.
- R2: The byte offsets are 0x00 for direction, 0x0C for pending, 0x10 for mask, 0x14 for the low sense register and 0x18 for the high sense register. Direction, mask and sense registers read back what was written. Every other offset reads 0.
- R3: Line n maps to bit (LINES-1-n) of `pins_in`, `dir_o`, `event_o` and `mask_o`. For example, line 5 is bit 26 and line 20 is bit 11.
- R4: The sense code for line n < 16 sits in bits [(15-n)*2+1:(15-n)*2] of the low sense register. For line n >= 16 it sits at (15-(n-16))*2 in the high sense register. Line 0 therefore uses bits 31:30 of the low register, and line 20 uses bits 23:22 of the high register.
- R5: Code 00 sets the line's pending flag on both a rising and a falling transition.
- R6: When `LEVEL_MODE` is 0, code 01 sets the flag only on a rising transition and code 10 only on a falling transition. A flag cleared while the line holds steady stays clear.
- R7: Code 11 never sets a pending flag.
- R8: Writing a one to a bit at the pending offset clears that flag. Writing a zero has no effect. A detection in the same cycle as the clear wins, and the flag stays set.
- R9: `irq_o` is 1 exactly when some flag is both pending and masked in (mask bit 1).
- R10: `RESTRICT` = 1 makes lines 28-31 (bits 3:0) input-only, and `RESTRICT` = 2 does the same for lines 0-3 (bits 31:28). Their direction bits always read 0, whatever is written.
- R11: When `LEVEL_MODE` is 1, code 01 sets the flag in every cycle the line is 1, and code 10 in every cycle it is 0. A clear is overridden while the level stays active.
- R12: A transition that first appears on `pins_in` before clock edge k shows in `event_o` right after edge k, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | LINES | Write data |
| reg_rdata | output | LINES | Read data for `reg_addr` (combinational) |
| pins_in | input | LINES | Synchronised input lines, line 0 at the top bit |
| dir_o | output | LINES | Direction register (1 = output) |
| event_o | output | LINES | Sticky pending flags |
| mask_o | output | LINES | Interrupt mask |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several properties on every cycle. A pending flag never drops without a write-one at the pending offset. A line with code 11 never gains a flag. Direction and mask writes land one cycle later, with input-only bits forced to 0. The interrupt stays low when nothing is both pending and masked in. The arming machine is also checked to keep flags clear through its priming cycle.

Only the bench scenarios can show the detection behaviour itself. They cover the field placement of each sense code, the edge-versus-level meaning of codes 01 and 10, and the one-edge latency. They also exercise the set-beats-clear collision and the re-assertion of level flags right after a clear.

// File: rtl/gis_pkg.sv
package gis_pkg;

    localparam int GIS_AW      = 5;
    localparam int GIS_FIELD_W = 2;
    localparam int GIS_RO_N    = 4;

    localparam logic [GIS_AW-1:0] OFF_DIR     = 5'h00;
    localparam logic [GIS_AW-1:0] OFF_EVENT   = 5'h0C;
    localparam logic [GIS_AW-1:0] OFF_MASK    = 5'h10;
    localparam logic [GIS_AW-1:0] OFF_SENSE_L = 5'h14;
    localparam logic [GIS_AW-1:0] OFF_SENSE_H = 5'h18;

    typedef enum logic [1:0] {
        SENSE_BOTH = 2'b00,
        SENSE_POS  = 2'b01,
        SENSE_NEG  = 2'b10,
        SENSE_RSVD = 2'b11
    } sense_e;

    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_e;

endpackage

// File: rtl/gis_arm_fsm.sv
module gis_arm_fsm
    import gis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic armed
);

    arm_state_e state_q;
    arm_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: PRIME_DONE (ST_PRIME -> ST_ARMED), STAY_ARMED (ST_ARMED -> ST_ARMED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            ST_PRIME: armed = 1'b0;
            ST_ARMED: armed = 1'b1;
        endcase
    end

endmodule

// File: rtl/gis_sense_cell.sv
module gis_sense_cell
    import gis_pkg::*;
#(
    parameter bit LEVEL_MODE = 1'b0
) (
    input  logic   pin,
    input  logic   prev,
    input  logic   armed,
    input  sense_e code,
    output logic   hit
);

    logic rise;
    logic fall;

    always_comb begin
        rise = pin & ~prev;
        fall = ~pin & prev;
        hit  = 1'b0;
        if (armed) begin
            unique case (code)
                SENSE_BOTH: hit = rise | fall;
                SENSE_POS:  hit = LEVEL_MODE ? pin : rise;
                SENSE_NEG:  hit = LEVEL_MODE ? ~pin : fall;
                SENSE_RSVD: hit = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gis_regs.sv
module gis_regs
    import gis_pkg::*;
#(
    parameter int               LINES   = 32,
    parameter logic [LINES-1:0] RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [GIS_AW-1:0] addr,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  hit,
    output logic [LINES-1:0]  rdata,
    output logic [LINES-1:0]  dir_q,
    output logic [LINES-1:0]  mask_q,
    output logic [LINES-1:0]  event_q,
    output logic [LINES-1:0]  sense_lo_q,
    output logic [LINES-1:0]  sense_hi_q
);

    logic [LINES-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (wr && addr == OFF_EVENT) begin
            clr_vec = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= '0;
            mask_q     <= '0;
            sense_lo_q <= '0;
            sense_hi_q <= '0;
        end else if (wr) begin
            unique case (addr)
                OFF_DIR:     dir_q      <= wdata & ~RO_MASK;
                OFF_MASK:    mask_q     <= wdata;
                OFF_SENSE_L: sense_lo_q <= wdata;
                OFF_SENSE_H: sense_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    // detection wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q <= '0;
        end else begin
            event_q <= (event_q & ~clr_vec) | hit;
        end
    end

    always_comb begin
        unique case (addr)
            OFF_DIR:     rdata = dir_q;
            OFF_EVENT:   rdata = event_q;
            OFF_MASK:    rdata = mask_q;
            OFF_SENSE_L: rdata = sense_lo_q;
            OFF_SENSE_H: rdata = sense_hi_q;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
    import gis_pkg::*;
#(
    parameter int LINES      = 32,
    parameter bit LEVEL_MODE = 1'b0,
    parameter int RESTRICT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [GIS_AW-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]  pins_in,
    output logic [LINES-1:0]  dir_o,
    output logic [LINES-1:0]  event_o,
    output logic [LINES-1:0]  mask_o,
    output logic              irq_o
);

    localparam int HALF = LINES / 2;
    localparam logic [LINES-1:0] RO_MASK =
        (RESTRICT == 1) ? {{(LINES-GIS_RO_N){1'b0}}, {GIS_RO_N{1'b1}}} :
        (RESTRICT == 2) ? {{GIS_RO_N{1'b1}}, {(LINES-GIS_RO_N){1'b0}}} :
                          {LINES{1'b0}};

    logic             armed;
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] hit;
    logic [LINES-1:0] sense_lo_w;
    logic [LINES-1:0] sense_hi_w;

    gis_arm_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pins_in;
        end
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        localparam int BIT  = LINES - 1 - n;
        localparam int SLOT = (n < HALF) ? (HALF - 1 - n) : (HALF - 1 - (n - HALF));
        logic [GIS_FIELD_W-1:0] raw;
        if (n < HALF) begin : g_lo
            assign raw = sense_lo_w[SLOT*GIS_FIELD_W +: GIS_FIELD_W];
        end else begin : g_hi
            assign raw = sense_hi_w[SLOT*GIS_FIELD_W +: GIS_FIELD_W];
        end
        gis_sense_cell #(.LEVEL_MODE(LEVEL_MODE)) u_cell (
            .pin   (pins_in[BIT]),
            .prev  (prev_q[BIT]),
            .armed (armed),
            .code  (sense_e'(raw)),
            .hit   (hit[BIT])
        );
    end

    gis_regs #(.LINES(LINES), .RO_MASK(RO_MASK)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .hit        (hit),
        .rdata      (reg_rdata),
        .dir_q      (dir_o),
        .mask_q     (mask_o),
        .event_q    (event_o),
        .sense_lo_q (sense_lo_w),
        .sense_hi_q (sense_hi_w)
    );

    assign irq_o = |(event_o & mask_o);

endmodule

// File: rtl/gpio_irq_sense_chk.sv
module gpio_irq_sense_chk
    import gis_pkg::*;
#(
    parameter int LINES    = 32,
    parameter int RESTRICT = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [GIS_AW-1:0] reg_addr,
    input logic [LINES-1:0]  reg_wdata,
    input logic [LINES-1:0]  dir_o,
    input logic [LINES-1:0]  event_o,
    input logic [LINES-1:0]  mask_o,
    input logic              irq_o,
    input logic              armed,
    input logic [LINES-1:0]  sense_lo_w,
    input logic [LINES-1:0]  sense_hi_w
);

    localparam int HALF = LINES / 2;
    localparam logic [LINES-1:0] RO_CHK =
        (RESTRICT == 1) ? {{(LINES-GIS_RO_N){1'b0}}, {GIS_RO_N{1'b1}}} :
        (RESTRICT == 2) ? {{GIS_RO_N{1'b1}}, {(LINES-GIS_RO_N){1'b0}}} :
                          {LINES{1'b0}};

    logic [LINES-1:0] wr_ones;
    assign wr_ones = (reg_wr && reg_addr == OFF_EVENT) ? reg_wdata : '0;

    // R8
    event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(event_o) & ~$past(wr_ones)) & ~event_o) == '0);

    // R1
    prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> event_o == '0);

    // R10
    dir_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_DIR) |=> dir_o == ($past(reg_wdata) & ~RO_CHK));

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_MASK) |=> mask_o == $past(reg_wdata));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0 || event_o == '0) |-> !irq_o);

    for (genvar n = 0; n < LINES; n++) begin : g_rsvd
        localparam int BIT  = LINES - 1 - n;
        localparam int SLOT = (n < HALF) ? (HALF - 1 - n) : (HALF - 1 - (n - HALF));
        logic [1:0] code;
        if (n < HALF) begin : g_lo
            assign code = sense_lo_w[SLOT*2 +: 2];
        end else begin : g_hi
            assign code = sense_hi_w[SLOT*2 +: 2];
        end
        // R7
        rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code == 2'b11 && !event_o[BIT]) |=> !event_o[BIT]);
    end

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.LINES(LINES), .RESTRICT(RESTRICT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .dir_o      (dir_o),
    .event_o    (event_o),
    .mask_o     (mask_o),
    .irq_o      (irq_o),
    .armed      (armed),
    .sense_lo_w (sense_lo_w),
    .sense_hi_w (sense_hi_w)
);

// File: tb/gpio_irq_sense_tb_top.sv
module gpio_irq_sense_tb_top;
    import gis_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  pins = '0;

    logic [W-1:0]  rd0, rd1, dir0, dir1, ev0, ev1, mk0, mk1;
    logic          irq0, irq1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_sense #(.LINES(W), .LEVEL_MODE(1'b0), .RESTRICT(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd0), .pins_in(pins),
        .dir_o(dir0), .event_o(ev0), .mask_o(mk0), .irq_o(irq0));

    gpio_irq_sense #(.LINES(W), .LEVEL_MODE(1'b1), .RESTRICT(2)) dut_lvl_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .pins_in(pins),
        .dir_o(dir1), .event_o(ev1), .mask_o(mk1), .irq_o(irq1));

    function automatic logic [W-1:0] lb(int n);
        return 32'h1 << (W - 1 - n);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [4:0] a);
        reg_addr = a;
        #1;
    endtask

    task automatic set_line(int n, logic v);
        pins[W-1-n] = v;
    endtask

    task automatic t_reset();
        // R1: line 2 high through reset and priming gives no flag
        step(); step();
        check("R1 event", ev0, '0);
        check("R1 event lvl", ev1, '0);
        check("R1 irq", {31'b0, irq0}, '0);
        rd(OFF_DIR);     check("R1 dir", rd0, '0);
        rd(OFF_MASK);    check("R1 mask", rd0, '0);
        rd(OFF_SENSE_L); check("R1 sense lo", rd0, '0);
        rd(OFF_SENSE_H); check("R1 sense hi", rd0, '0);
        set_line(2, 1'b0);
        step();
        wr(OFF_EVENT, '1);
        check("R1 cleared", ev0, '0);
    endtask

    task automatic t_map();
        wr(OFF_SENSE_L, 32'h0000_0000);
        wr(OFF_MASK, 32'h1234_5678);
        rd(OFF_MASK); check("R2 mask readback", rd0, 32'h1234_5678);
        wr(OFF_SENSE_H, 32'h0000_0000);
        rd(5'h04); check("R2 unmapped", rd0, '0);
        wr(OFF_MASK, '0);
        rd(OFF_MASK); check("R2 mask clear", rd0, '0);
    endtask

    task automatic t_both_edge();
        set_line(5, 1'b1);
        #1;
        check("R12 not before edge", ev0, '0);
        step();
        check("R5 R3 rise both", ev0, lb(5));
        check("R5 rise both lvl", ev1, lb(5));
        wr(OFF_EVENT, lb(5));
        set_line(5, 1'b0);
        step();
        check("R5 fall both", ev0, lb(5));
        wr(OFF_EVENT, '1);
        check("R5 cleared", ev0, '0);
    endtask

    task automatic t_rise_fall();
        wr(OFF_SENSE_L, 32'h4003_0000);
        wr(OFF_SENSE_H, 32'h0080_0000);
        rd(OFF_SENSE_L); check("R2 sense lo readback", rd0, 32'h4003_0000);
        rd(OFF_SENSE_H); check("R2 sense hi readback", rd0, 32'h0080_0000);
        wr(OFF_EVENT, '1);
        check("R6 start clear", ev0, '0);
        set_line(0, 1'b1); step();
        check("R6 R4 line0 rising", ev0, lb(0));
        set_line(20, 1'b1); step();
        check("R6 line20 rise ignored", ev0, lb(0));
        set_line(20, 1'b0); step();
        check("R6 R4 line20 falling", ev0, lb(0) | lb(20));
        set_line(0, 1'b0); step();
        check("R6 line0 fall ignored", ev0, lb(0) | lb(20));
        set_line(7, 1'b1); step();
        set_line(7, 1'b0); step();
        check("R7 reserved code", ev0, lb(0) | lb(20));
    endtask

    task automatic t_w1c();
        wr(OFF_EVENT, '0); step();
        check("R8 write zero", ev0, lb(0) | lb(20));
        wr(OFF_EVENT, lb(0));
        check("R8 write one", ev0, lb(20));
        set_line(0, 1'b1);
        wr(OFF_EVENT, lb(0));
        check("R8 set beats clear", ev0, lb(0) | lb(20));
    endtask

    task automatic t_irq();
        check("R9 irq masked out", {31'b0, irq0}, '0);
        wr(OFF_MASK, lb(20));
        check("R9 R3 mask bit", mk0, 32'h0000_0800);
        check("R9 irq raised", {31'b0, irq0}, 32'h1);
        wr(OFF_EVENT, lb(20));
        check("R9 irq dropped", {31'b0, irq0}, '0);
        wr(OFF_MASK, '0);
    endtask

    task automatic t_level();
        // line0 held 1 (code 01), line20 held 0 (code 10)
        wr(OFF_EVENT, '1);
        check("R11 level reasserts", ev1, lb(0) | lb(20));
        check("R6 edge stays clear", ev0, '0);
        set_line(0, 1'b0);
        set_line(20, 1'b1);
        step();
        wr(OFF_EVENT, '1);
        check("R11 inactive clears", ev1, '0);
        check("R6 edge quiet", ev0, '0);
    endtask

    task automatic t_dir();
        wr(OFF_DIR, '1);
        rd(OFF_DIR);
        check("R10 hi lines input only", rd0, 32'hFFFF_FFF0);
        check("R10 lo lines input only", rd1, 32'h0FFF_FFFF);
        wr(OFF_DIR, 32'h8000_0001);
        check("R10 R3 dir partial", dir0, 32'h8000_0000);
        check("R10 dir partial lvl", dir1, 32'h0000_0001);
    endtask

    initial begin
        set_line(2, 1'b1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_both_edge();
        t_rise_fall();
        t_w1c();
        t_irq();
        t_level();
        t_dir();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule